// File: doc/BRIEF.md
# Strided Interleave DMA Address Generator

This block produces the address stream for a scratch-memory DMA channel working in interleave mode. After a start pulse it walks a total number of 16-byte quadwords and emits one beat per quadword. Each beat carries a main-memory address and a scratch-memory address. The walk is split into chunks of a programmed transfer size. After every chunk the main-memory pointer jumps forward by a programmed gap of skip quadwords. The scratch pointer runs on contiguously and wraps inside a 16 KB window.

Beats are offered with a valid signal and are consumed when the ready input is high. A remaining-count output shows how many quadwords are still to be issued. A one-cycle done pulse closes the transfer. Data movement and the memories themselves sit outside this block.

Top module: `sidma_interleave_agen`

## Requirements
- R1: After reset the block is idle. `beat_valid_o` and `done_o` are low and `remaining_qw_o` is zero.
- R2: A transfer size of zero makes the whole transfer a single chunk, so no skip gap is inserted anywhere.
- R3: Each chunk holds min(transfer size, quadwords still remaining) beats. A transfer size larger than the total gives one short chunk.
- R4: The first scratch address is `spr_addr_i & 0x3FF0`. Each accepted beat advances it by 16, wrapped with mask 0x3FFF. Bits 31:14 of `beat_spr_addr_o` are always zero.
- R5: The first main address is `main_addr_i`. Each accepted beat advances it by 16. The last beat of a chunk advances it by 16 + skip×16 instead.
- R6: A beat is consumed only in a cycle where `beat_valid_o` and `beat_ready_i` are both high. While ready is low, valid stays high and both addresses hold.
- R7: `done_o` is high for exactly one cycle, the cycle after the final beat is accepted. In that cycle `beat_valid_o` is low and `remaining_qw_o` is zero.
- R8: A start with a total of zero issues no beat, and `done_o` is high in the cycle after the start.
- R9: A start pulse that arrives while a transfer is in progress, or during its done cycle, is ignored.
- R10: `remaining_qw_o` loads the total on start and drops by one on each accepted beat. It stays zero once the transfer is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| total_qw_i | input | 16 | Total quadwords to move |
| xfer_qw_i | input | 16 | Chunk (transfer) size in quadwords, 0 = one chunk |
| skip_qw_i | input | 16 | Gap in quadwords after each chunk in main memory |
| main_addr_i | input | 32 | Main-memory start byte address |
| spr_addr_i | input | 32 | Scratch start byte address |
| beat_ready_i | input | 1 | Consumer accepts the current beat |
| beat_valid_o | output | 1 | A beat is offered |
| beat_main_addr_o | output | 32 | Main-memory address of the offered beat |
| beat_spr_addr_o | output | 32 | Scratch address of the offered beat |
| remaining_qw_o | output | 16 | Quadwords not yet accepted |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench goes after four corner cases:
- A transfer size of zero. A design that took zero literally would stall or insert a skip after every beat.
- A last chunk shorter than the transfer size. A design that clamped it wrongly would apply the gap at the wrong beat or overrun the total.
- A scratch start just below the 16 KB boundary. A design that got the wrap wrong would leak address bits above bit 13.
- A zero total, a stalled consumer and a second start during a transfer. Here a faulty design would emit a phantom beat, drop or repeat addresses under back-pressure, or restart with the new parameters.

// File: rtl/sidma_pkg.sv
package sidma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } sidma_state_e;
endpackage

// File: rtl/sidma_chunk_ctr.sv
module sidma_chunk_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] total,
  input  logic [CNT_W-1:0] tsize,
  input  logic             fire,
  output logic [CNT_W-1:0] rem_total,
  output logic             chunk_end,
  output logic             last_beat
);
  logic [CNT_W-1:0] tsz_q;
  logic [CNT_W-1:0] chunk_left;

  function automatic logic [CNT_W-1:0] min_cnt(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [CNT_W-1:0] eff_size(input logic [CNT_W-1:0] sz,
                                                input logic [CNT_W-1:0] tot);
    return (sz == '0) ? tot : sz;
  endfunction

  assign chunk_end = (chunk_left == CNT_W'(1));
  assign last_beat = (rem_total == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_total  <= '0;
      chunk_left <= '0;
      tsz_q      <= '0;
    end else if (load) begin
      rem_total  <= total;
      tsz_q      <= eff_size(tsize, total);
      chunk_left <= min_cnt(eff_size(tsize, total), total);
    end else if (fire) begin
      rem_total <= rem_total - CNT_W'(1);
      if (chunk_end) chunk_left <= min_cnt(tsz_q, rem_total - CNT_W'(1));
      else           chunk_left <= chunk_left - CNT_W'(1);
    end
  end

  AST_REM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !fire) |=> $stable(rem_total)); // R10
  AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load) |=> (rem_total == $past(rem_total) - CNT_W'(1))); // R10
  AST_CHUNK_NOT_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last_beat) |-> chunk_end); // R3
endmodule

// File: rtl/sidma_addr_gen.sv
module sidma_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int SPR_AW = 14,
  parameter int QW_SH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] main_start,
  input  logic [ADDR_W-1:0] spr_start,
  input  logic [CNT_W-1:0]  skip,
  input  logic              fire,
  input  logic              chunk_end,
  output logic [ADDR_W-1:0] main_addr,
  output logic [ADDR_W-1:0] spr_addr
);
  localparam logic [ADDR_W-1:0] SPR_MASK = ADDR_W'((64'd1 << SPR_AW) - 64'd1);
  localparam logic [ADDR_W-1:0] QW_BYTES = ADDR_W'(64'd1 << QW_SH);
  localparam logic [ADDR_W-1:0] QW_ALIGN = ~(QW_BYTES - ADDR_W'(1));

  logic [CNT_W-1:0] skip_q;

  function automatic logic [ADDR_W-1:0] spr_first(input logic [ADDR_W-1:0] a);
    return a & SPR_MASK & QW_ALIGN;
  endfunction

  function automatic logic [ADDR_W-1:0] spr_next(input logic [ADDR_W-1:0] a);
    return (a + QW_BYTES) & SPR_MASK;
  endfunction

  function automatic logic [ADDR_W-1:0] main_next(input logic [ADDR_W-1:0] a,
                                                  input logic             jump,
                                                  input logic [CNT_W-1:0] gap);
    logic [ADDR_W-1:0] gap_b;
    gap_b = jump ? (ADDR_W'(gap) << QW_SH) : '0;
    return a + QW_BYTES + gap_b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_addr <= '0;
      spr_addr  <= '0;
      skip_q    <= '0;
    end else if (load) begin
      main_addr <= main_start;
      spr_addr  <= spr_first(spr_start);
      skip_q    <= skip;
    end else if (fire) begin
      main_addr <= main_next(main_addr, chunk_end, skip_q);
      spr_addr  <= spr_next(spr_addr);
    end
  end

  AST_SPR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_addr & ~SPR_MASK) == '0); // R4
  AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !fire) |=> ($stable(main_addr) && $stable(spr_addr))); // R6
  AST_MAIN_INNER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load && !chunk_end) |=> (main_addr == $past(main_addr) + QW_BYTES)); // R5
endmodule

// File: rtl/sidma_interleave_agen.sv
module sidma_interleave_agen
  import sidma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int SPR_AW = 14,
  parameter int QW_SH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  total_qw_i,
  input  logic [CNT_W-1:0]  xfer_qw_i,
  input  logic [CNT_W-1:0]  skip_qw_i,
  input  logic [ADDR_W-1:0] main_addr_i,
  input  logic [ADDR_W-1:0] spr_addr_i,
  input  logic              beat_ready_i,
  output logic              beat_valid_o,
  output logic [ADDR_W-1:0] beat_main_addr_o,
  output logic [ADDR_W-1:0] beat_spr_addr_o,
  output logic [CNT_W-1:0]  remaining_qw_o,
  output logic              done_o
);
  sidma_state_e st_q, st_d;

  logic load_ev;
  logic fire_ev;
  logic chunk_end_ev;
  logic last_beat_ev;

  assign load_ev      = start_i && (st_q == ST_IDLE);
  assign beat_valid_o = (st_q == ST_RUN);
  assign done_o       = (st_q == ST_FIN);
  assign fire_ev      = beat_valid_o && beat_ready_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (load_ev) st_d = (total_qw_i == '0) ? ST_FIN : ST_RUN;
      ST_RUN:  if (fire_ev && last_beat_ev) st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  sidma_chunk_ctr #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_ev),
    .total     (total_qw_i),
    .tsize     (xfer_qw_i),
    .fire      (fire_ev),
    .rem_total (remaining_qw_o),
    .chunk_end (chunk_end_ev),
    .last_beat (last_beat_ev)
  );

  sidma_addr_gen #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .SPR_AW (SPR_AW),
    .QW_SH  (QW_SH)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_ev),
    .main_start (main_addr_i),
    .spr_start  (spr_addr_i),
    .skip       (skip_qw_i),
    .fire       (fire_ev),
    .chunk_end  (chunk_end_ev),
    .main_addr  (beat_main_addr_o),
    .spr_addr   (beat_spr_addr_o)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !beat_ready_i) |=> (beat_valid_o && $stable(beat_main_addr_o)
                                         && $stable(beat_spr_addr_o))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!beat_valid_o && remaining_qw_o == '0)); // R7
  AST_ZERO_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && total_qw_i == '0) |=> (done_o && !beat_valid_o)); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && beat_valid_o && !beat_ready_i) |=> $stable(remaining_qw_o)); // R9
endmodule

// File: tb/sidma_interleave_agen_bench.sv
`timescale 1ns/1ps
module sidma_interleave_agen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] total_qw_i = '0, xfer_qw_i = '0, skip_qw_i = '0;
  logic [31:0] main_addr_i = '0, spr_addr_i = '0;
  logic        beat_ready_i = 1'b0;
  logic        beat_valid_o, done_o;
  logic [31:0] beat_main_addr_o, beat_spr_addr_o;
  logic [15:0] remaining_qw_o;

  int n_checks = 0;
  int n_errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  sidma_interleave_agen u_sidma_interleave_agen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .total_qw_i(total_qw_i),
    .xfer_qw_i(xfer_qw_i), .skip_qw_i(skip_qw_i), .main_addr_i(main_addr_i),
    .spr_addr_i(spr_addr_i), .beat_ready_i(beat_ready_i), .beat_valid_o(beat_valid_o),
    .beat_main_addr_o(beat_main_addr_o), .beat_spr_addr_o(beat_spr_addr_o),
    .remaining_qw_o(remaining_qw_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s (%s) %s: actual=%h expected=%h", req, cur_req, what, act, exp);
    end
  endtask

  // Behavioural reference: expected beats kept as queues.
  int          ms = 0;        // 0 idle, 1 issuing, 2 finishing
  int          mrem = 0;
  logic [31:0] q_main[$];
  logic [31:0] q_spr[$];

  task automatic build_expect();
    int unsigned chunk, left, take;
    logic [31:0] m, s;
    chunk = (xfer_qw_i == 0) ? total_qw_i : xfer_qw_i;
    left  = total_qw_i;
    m = main_addr_i;
    s = spr_addr_i & 32'h0000_3FF0;
    while (left > 0) begin
      take = (chunk < left) ? chunk : left;
      for (int i = 0; i < int'(take); i++) begin
        q_main.push_back(m);
        q_spr.push_back(s);
        m = m + 32'd16;
        s = (s + 32'd16) & 32'h0000_3FFF;
      end
      m = m + {12'd0, skip_qw_i, 4'd0};
      left = left - take;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(beat_valid_o === (ms == 1), "R6", "valid", {31'd0, beat_valid_o}, {31'd0, ms == 1});
      chk(done_o === (ms == 2), "R7", "done", {31'd0, done_o}, {31'd0, ms == 2});
      chk(remaining_qw_o === 16'(mrem), "R10", "remaining", {16'd0, remaining_qw_o}, 32'(mrem));
      if (ms == 1 && q_main.size() > 0) begin
        chk(beat_main_addr_o === q_main[0], "R5", "main addr", beat_main_addr_o, q_main[0]);
        chk(beat_spr_addr_o === q_spr[0], "R4", "scratch addr", beat_spr_addr_o, q_spr[0]);
      end
      case (ms)
        0: if (start_i) begin
             build_expect();
             mrem = total_qw_i;
             ms = (total_qw_i == 0) ? 2 : 1;
           end
        1: if (beat_ready_i) begin
             void'(q_main.pop_front());
             void'(q_spr.pop_front());
             mrem--;
             if (q_main.size() == 0) ms = 2;
           end
        default: ms = 0;
      endcase
    end
  end

  // stall_per: 0 = always ready, else ready low on every stall_per-th cycle.
  // busy_at: cycle at which a spurious start is pulsed (R9), 0 = none.
  task automatic run_case(input string req, input int total, input int tsz, input int skip,
                          input logic [31:0] ma, input logic [31:0] sa,
                          input int stall_per, input int busy_at);
    int k;
    bit seen_done;
    cur_req = req;
    @(posedge clk); #1;
    total_qw_i = 16'(total); xfer_qw_i = 16'(tsz); skip_qw_i = 16'(skip);
    main_addr_i = ma; spr_addr_i = sa; start_i = 1'b1;
    beat_ready_i = (stall_per == 0);
    @(posedge clk); #1;
    start_i = 1'b0;
    k = 0;
    seen_done = 1'b0;
    while (!seen_done && k < 5000) begin
      k++;
      beat_ready_i = (stall_per == 0) ? 1'b1 : ((k % stall_per) != 0);
      if (busy_at != 0 && k == busy_at) begin
        start_i = 1'b1; total_qw_i = 16'd50; xfer_qw_i = 16'd1;
        skip_qw_i = 16'd9; main_addr_i = 32'hDEAD_0000; spr_addr_i = 32'h200;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      if (done_o) seen_done = 1'b1;
      @(posedge clk); #1;
    end
    start_i = 1'b0;
    beat_ready_i = 1'b0;
    chk(seen_done, req, "done reached", {31'd0, seen_done}, 32'd1);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(beat_valid_o === 1'b0, "R1", "valid after reset", {31'd0, beat_valid_o}, 32'd0);
    chk(done_o === 1'b0, "R1", "done after reset", {31'd0, done_o}, 32'd0);
    chk(remaining_qw_o === 16'd0, "R1", "remaining after reset", {16'd0, remaining_qw_o}, 32'd0);

    run_case("R3", 10, 4, 2, 32'h0000_1000, 32'h0000_0100, 0, 0);      // short last chunk
    run_case("R2", 5, 0, 7, 32'h0002_0000, 32'h0000_0040, 0, 0);       // size zero: one chunk
    run_case("R4", 6, 3, 1, 32'h0000_8000, 32'hABC0_3FE5, 3, 0);       // wrap + unaligned
    run_case("R8", 0, 4, 2, 32'h0000_4000, 32'h0000_0000, 0, 0);       // zero total
    run_case("R9", 8, 2, 3, 32'h0010_0000, 32'h0000_1000, 2, 3);       // start while busy
    run_case("R6", 7, 20, 5, 32'hFFFF_FFC0, 32'h0000_3FF0, 2, 0);      // size > total, stalls
    run_case("R5", 12, 1, 1, 32'h0000_0000, 32'h0000_0000, 4, 0);      // chunk of one
    run_case("R7", 1, 1, 0, 32'h0000_0010, 32'h0000_0010, 0, 0);       // single beat

    cur_req = "R10";
    @(negedge clk);
    chk(remaining_qw_o === 16'd0, "R10", "remaining idle after runs", {16'd0, remaining_qw_o}, 32'd0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired (%s)", cur_req);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule